// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a processor access to a small bank of chipset configuration registers through two byte-wide I/O locations. A write to the index port (22h) names a register. The next access to the data port (24h) reads or writes that register. An index stays usable for one data access only. After that access it is marked stale. A repeated data access without a new index write therefore leaves the registers as they are. Only thirteen indexes, 20h to 2Ch, are backed by storage. Two general-purpose scratch bytes sit at their own addresses, E1h and E2h.

All register bits leave the block on a flat bus, so that the memory, cache and timing decoders elsewhere can use them without going through the I/O path. A one-cycle strobe per register marks each register that has just been rewritten. The I/O side is a plain strobe interface with no back-pressure. A write or read strobe is taken in the cycle where it is high. Read data is combinational and valid during that same cycle.

Top module: `cfg_index_window`

## Requirements
- R1: After an index write to 22h that names an index in 20h..2Ch, a write to 24h stores the byte in that register. After a fresh index write, a read of 24h returns the byte. The first and last registers of the range both behave this way.
- R2: A data write to 24h that has no index write to 22h since the previous data access is ignored. A second data read made the same way returns FFh.
- R3: A data read also uses up the index. A read of 24h right after another data read returns FFh.
- R4: A data access whose index is outside 20h..2Ch changes no register, raises no update strobe, and reads back FFh.
- R5: Bits 7:6 of register 20h always read 01b. Any value written to those bits is dropped, and bits 5:0 are stored as written.
- R6: After reset the registers hold these values: 20h=40h, 22h=84h, 24h=87h, 25h=F0h (read and write wait-state fields both 11b), 27h=91h, 28h=80h, 29h=10h, 2Ah=80h, 2Bh=10h, and 00h in all the others. The index is stale after reset.
- R7: The scratch bytes at E1h and E2h reset to FFh and can be read and written directly, with no index.
- R8: A read of the index port 22h returns FFh. So does a read of any address that is not decoded.
- R9: `cfg_bus[8*i+7:8*i]` holds register 20h+i. In the cycle after an accepted data write, `cfg_upd` has only bit i set. It is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, FFh when nothing is selected |
| cfg_bus | output | 104 | All registers, with register 20h+i in byte i |
| cfg_upd | output | 13 | One-cycle strobe marking the register just written |

## Verification
The assertions take it as given that `io_wr` and `io_rd` are never high in the same cycle. They also take it that the address and write data are steady while a strobe is high. The stimulus drives each access as a single-cycle strobe, with its address and data set half a cycle before the edge and an idle cycle between accesses, so both conditions always hold. The back-to-back read property has no matching case in the stimulus, because of that idle cycle. The same behaviour is instead checked at the ports by a data read that follows another data read.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  // Reset value of the register at offset i from the window base.
  function automatic logic [7:0] reg_default(input int i);
    case (i)
      0:       return 8'h40;
      2:       return 8'h84;
      4:       return 8'h87;
      5:       return 8'hF0;
      7:       return 8'h91;
      8:       return 8'h80;
      9:       return 8'h10;
      10:      return 8'h80;
      11:      return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  // Bits that software cannot change (the revision field of offset 0).
  function automatic logic [7:0] reg_ro_mask(input int i);
    return (i == 0) ? 8'hC0 : 8'h00;
  endfunction

endpackage

// File: rtl/cfg_index_tracker.sv
module cfg_index_tracker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_load,
  input  logic       data_touch,
  input  logic [7:0] idx_in,
  output logic [7:0] idx_q,
  output logic       idx_live
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= 8'h00;
      idx_live <= 1'b0;
    end else if (idx_load) begin
      idx_q    <= idx_in;
      idx_live <= 1'b1;
    end else if (data_touch) begin
      idx_live <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int NUM_REGS = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [NUM_REGS-1:0]   sel,
  input  logic [7:0]            wdata,
  output logic [8*NUM_REGS-1:0] bank,
  output logic [NUM_REGS-1:0]   upd
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] DEF = cfgwin_pkg::reg_default(i);
    localparam logic [7:0] RO  = cfgwin_pkg::reg_ro_mask(i);
    logic [7:0] q;
    logic       hit;
    assign hit = wr_en && sel[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q      <= DEF;
        upd[i] <= 1'b0;
      end else begin
        upd[i] <= hit;
        if (hit) q <= (wdata & ~RO) | (DEF & RO);
      end
    end
    assign bank[8*i +: 8] = q;
  end
endmodule

// File: rtl/cfg_scratch.sv
module cfg_scratch #(
  parameter int NUM_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [NUM_BYTES-1:0]   sel,
  input  logic [7:0]             wdata,
  output logic [8*NUM_BYTES-1:0] bytes_q
);
  for (genvar j = 0; j < NUM_BYTES; j++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bytes_q[8*j +: 8] <= 8'hFF;
      else if (wr_en && sel[j])   bytes_q[8*j +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_index_window.sv
module cfg_index_window #(
  parameter logic [7:0] INDEX_PORT = 8'h22,
  parameter logic [7:0] DATA_PORT  = 8'h24,
  parameter logic [7:0] WIN_BASE   = 8'h20,
  parameter int         NUM_REGS   = 13,
  parameter logic [7:0] SCR_BASE   = 8'hE1,
  parameter int         NUM_SCR    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic [8*NUM_REGS-1:0] cfg_bus,
  output logic [NUM_REGS-1:0]   cfg_upd
);
  logic [7:0]           idx_q;
  logic                 idx_live;
  logic                 at_index, at_data;
  logic [NUM_REGS-1:0]  reg_hit;
  logic [NUM_SCR-1:0]   scr_hit;
  logic [8*NUM_SCR-1:0] scr_q;

  assign at_index = (io_addr == INDEX_PORT);
  assign at_data  = (io_addr == DATA_PORT);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_rhit
    assign reg_hit[i] = idx_live && (idx_q == WIN_BASE + 8'(i));
  end
  for (genvar j = 0; j < NUM_SCR; j++) begin : g_shit
    assign scr_hit[j] = (io_addr == SCR_BASE + 8'(j));
  end

  cfg_index_tracker u_idx (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_load   (io_wr && at_index),
    .data_touch ((io_wr || io_rd) && at_data),
    .idx_in     (io_wdata),
    .idx_q      (idx_q),
    .idx_live   (idx_live)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (io_wr && at_data),
    .sel   (reg_hit),
    .wdata (io_wdata),
    .bank  (cfg_bus),
    .upd   (cfg_upd)
  );

  cfg_scratch #(.NUM_BYTES(NUM_SCR)) u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (io_wr),
    .sel     (scr_hit),
    .wdata   (io_wdata),
    .bytes_q (scr_q)
  );

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd) begin
      if (at_data) begin
        for (int i = 0; i < NUM_REGS; i++)
          if (reg_hit[i]) io_rdata = cfg_bus[8*i +: 8];
      end
      for (int j = 0; j < NUM_SCR; j++)
        if (scr_hit[j]) io_rdata = scr_q[8*j +: 8];
    end
  end
endmodule

// File: rtl/cfg_index_window_chk.sv
module cfg_index_window_chk #(
  parameter logic [7:0] INDEX_PORT = 8'h22,
  parameter logic [7:0] DATA_PORT  = 8'h24,
  parameter int         NUM_REGS   = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [7:0]            io_addr,
  input logic                  io_wr,
  input logic                  io_rd,
  input logic [7:0]            io_rdata,
  input logic [8*NUM_REGS-1:0] cfg_bus,
  input logic [NUM_REGS-1:0]   cfg_upd
);
  assert_upd_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_upd));

  assert_upd_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_upd != '0) |-> $past(io_wr && io_addr == DATA_PORT));

  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == DATA_PORT) |=> $stable(cfg_bus));

  assert_revision_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bus[7:6] == 2'b01);

  assert_index_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == INDEX_PORT) |-> io_rdata == 8'hFF);

  assert_reread_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == DATA_PORT) ##1 (io_rd && io_addr == DATA_PORT)
      |-> io_rdata == 8'hFF);
endmodule

bind cfg_index_window cfg_index_window_chk #(
  .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT), .NUM_REGS(NUM_REGS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_rdata(io_rdata), .cfg_bus(cfg_bus), .cfg_upd(cfg_upd)
);

// File: tb/cfg_index_window_tb_top.sv
module cfg_index_window_tb_top;
  localparam int NR = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    io_addr = 8'h00;
  logic          io_wr = 1'b0;
  logic          io_rd = 1'b0;
  logic [7:0]    io_wdata = 8'h00;
  logic [7:0]    io_rdata;
  logic [8*NR-1:0] cfg_bus;
  logic [NR-1:0] cfg_upd;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  cfg_index_window dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_bus(cfg_bus), .cfg_upd(cfg_upd)
  );

  typedef struct packed {
    logic       rd;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] expv;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h22, 8'h25, 8'h00, 4'd6}, '{1'b1, 8'h24, 8'h00, 8'hF0, 4'd6},  // R6
    '{1'b0, 8'h22, 8'h21, 8'h00, 4'd1}, '{1'b0, 8'h24, 8'hA5, 8'h00, 4'd1},  // R1
    '{1'b0, 8'h22, 8'h21, 8'h00, 4'd1}, '{1'b1, 8'h24, 8'h00, 8'hA5, 4'd1},
    '{1'b1, 8'h24, 8'h00, 8'hFF, 4'd3},                                       // R3
    '{1'b0, 8'h24, 8'h11, 8'h00, 4'd2}, '{1'b0, 8'h22, 8'h21, 8'h00, 4'd2},  // R2
    '{1'b1, 8'h24, 8'h00, 8'hA5, 4'd2},
    '{1'b0, 8'h22, 8'h20, 8'h00, 4'd5}, '{1'b0, 8'h24, 8'hFF, 8'h00, 4'd5},  // R5
    '{1'b0, 8'h22, 8'h20, 8'h00, 4'd5}, '{1'b1, 8'h24, 8'h00, 8'h7F, 4'd5},
    '{1'b0, 8'h22, 8'h30, 8'h00, 4'd4}, '{1'b0, 8'h24, 8'h55, 8'h00, 4'd4},  // R4
    '{1'b0, 8'h22, 8'h30, 8'h00, 4'd4}, '{1'b1, 8'h24, 8'h00, 8'hFF, 4'd4},
    '{1'b0, 8'h22, 8'h2C, 8'h00, 4'd1}, '{1'b0, 8'h24, 8'h3C, 8'h00, 4'd1},
    '{1'b0, 8'h22, 8'h2C, 8'h00, 4'd1}, '{1'b1, 8'h24, 8'h00, 8'h3C, 4'd1},
    '{1'b1, 8'h24, 8'h00, 8'hFF, 4'd2},
    '{1'b0, 8'h22, 8'h1F, 8'h00, 4'd4}, '{1'b1, 8'h24, 8'h00, 8'hFF, 4'd4},
    '{1'b1, 8'h22, 8'h00, 8'hFF, 4'd8},                                       // R8
    '{1'b1, 8'hE1, 8'h00, 8'hFF, 4'd7}, '{1'b0, 8'hE2, 8'h12, 8'h00, 4'd7},  // R7
    '{1'b1, 8'hE2, 8'h00, 8'h12, 4'd7},
    '{1'b1, 8'h60, 8'h00, 8'hFF, 4'd8}
  };

  function automatic logic [7:0] exp_default(input int i);
    logic [7:0] d [NR] = '{8'h40, 8'h00, 8'h84, 8'h00, 8'h87, 8'hF0, 8'h00,
                           8'h91, 8'h80, 8'h10, 8'h80, 8'h10, 8'h00};
    return d[i];
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    logic [8*NR-1:0] snap;
    repeat (3) @(negedge clk);
    // R6: reset state on the parallel bus
    for (int i = 0; i < NR; i++) check("R6 default", cfg_bus[8*i +: 8], exp_default(i));
    check("R9 no strobe at reset", cfg_upd, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      if (TBL[k].rd) begin
        io_read(TBL[k].addr, rv);
        check($sformatf("R%0d vec%0d", TBL[k].req, k), rv, TBL[k].expv);
      end else begin
        io_write(TBL[k].addr, TBL[k].data);
      end
    end

    // R9: update strobe and parallel bus for register 23h
    io_write(8'h22, 8'h23);
    io_write(8'h24, 8'h5A);
    check("R9 strobe bit", cfg_upd, 13'h0008);
    check("R9 bus byte", cfg_bus[8*3 +: 8], 8'h5A);
    @(negedge clk);
    check("R9 strobe clears", cfg_upd, 0);

    // R4: out-of-window write leaves every register and strobe alone
    snap = cfg_bus;
    io_write(8'h22, 8'h2D);
    io_write(8'h24, 8'h77);
    check("R4 no strobe", cfg_upd, 0);
    check("R4 bus unchanged", cfg_bus, snap);

    // R2: stale-index write leaves the bus alone
    io_write(8'h24, 8'h99);
    check("R2 bus unchanged", cfg_bus, snap);

    // R6 R7: reset restores defaults, scratch and a stale index
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NR; i++) check("R6 default after reset", cfg_bus[8*i +: 8], exp_default(i));
    io_read(8'hE2, rv);
    check("R7 scratch reset", rv, 8'hFF);
    io_read(8'h24, rv);
    check("R6 index stale after reset", rv, 8'hFF);

    finish_run();
  end
endmodule